// File: doc/BRIEF.md
# Four-State Up/Down Counter with Arrival-at-Two Detect

This block is a two-bit synchronous state machine that steps through four states on every rising clock edge. A single direction input picks the step. When the input is low the machine moves one state forward, and when it is high the machine moves one state back. Both directions wrap around. The present state is driven out as a two-bit count.

A second output, the arrival flag, belongs to the transition and not to the state. It is a combinational function of the present state and the direction input. It is high during any cycle in which the step that the next edge would take ends in state two. The flag can therefore be used as an early warning one cycle before the count shows two.

States and their count values:
- ZERO = 00
- ONE = 01
- TWO = 10
- THREE = 11

Transitions with the direction low (up):
- ZERO→ONE
- ONE→TWO (arrival)
- TWO→THREE
- THREE→ZERO

Transitions with the direction high (down):
- ZERO→THREE
- THREE→TWO (arrival)
- TWO→ONE
- ONE→ZERO

Top module: `quad_updown_seek2`

## Requirements
- R1: With `rst` high at a rising edge, the next `count` is 00, whatever the state and `dir_down` are.
- R2: With `rst` low and `dir_down` = 0 at a rising edge, `count` advances by one modulo 4 (00→01→10→11→00).
- R3: With `rst` low and `dir_down` = 1 at a rising edge, `count` goes back by one modulo 4 (00→11→10→01→00).
- R4: `hit_two` is 1 while `count` = 01 and `dir_down` = 0.
- R5: `hit_two` is 1 while `count` = 11 and `dir_down` = 1.
- R6: `hit_two` is 0 for every other pair of `count` and `dir_down`. Whenever it is 1 and no reset is applied, the next `count` is 10.
- R7: `hit_two` follows a change on `dir_down` within the same cycle, with no register in between.
- R8: When `dir_down` changes during a cycle, the value present at the next rising edge alone decides the direction of that step.
- R9: A reset that meets a pending arrival wins. The count goes to 00 and not 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset to state ZERO |
| dir_down | input | 1 | Step direction: 0 counts up, 1 counts down |
| count | output | 2 | Present state code |
| hit_two | output | 1 | High while the pending step lands on state two |

## Verification
Reset and an arrival-at-two can fall in the same cycle. The bench provokes this by placing the machine in ONE with the direction low, and again in THREE with the direction high. In each case it first confirms that `hit_two` is high, then raises `rst` before the edge. It judges the result by reading `count` after that edge: it must be 00, not 10.

// File: rtl/qsu_pkg.sv
package qsu_pkg;
    localparam int CNT_W    = 2;
    localparam int N_STATES = 1 << CNT_W;

    typedef enum logic [CNT_W-1:0] {
        ST_ZERO  = 2'b00,
        ST_ONE   = 2'b01,
        ST_TWO   = 2'b10,
        ST_THREE = 2'b11
    } qsu_state_e;

    localparam qsu_state_e TARGET_ST = ST_TWO;
endpackage

// File: rtl/qsu_next.sv
module qsu_next
    import qsu_pkg::*;
(
    input  qsu_state_e cur,
    input  logic       dir_down,
    output qsu_state_e nxt
);
    always_comb begin
        nxt = ST_ZERO;
        unique case (cur)
            ST_ZERO:  nxt = dir_down ? ST_THREE : ST_ONE;
            ST_ONE:   nxt = dir_down ? ST_ZERO  : ST_TWO;
            ST_TWO:   nxt = dir_down ? ST_ONE   : ST_THREE;
            ST_THREE: nxt = dir_down ? ST_TWO   : ST_ZERO;
            default:  nxt = ST_ZERO;
        endcase
    end
endmodule

// File: rtl/qsu_detect.sv
module qsu_detect
    import qsu_pkg::*;
(
    input  qsu_state_e cur,
    input  logic       dir_down,
    output logic       hit
);
    // Mealy output: set only on the two edges that enter the target state
    always_comb begin
        hit = 1'b0;
        unique case (cur)
            ST_ONE:   hit = ~dir_down;
            ST_THREE: hit = dir_down;
            ST_ZERO,
            ST_TWO:   hit = 1'b0;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/quad_updown_seek2.sv
module quad_updown_seek2
    import qsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_down,
    output logic [CNT_W-1:0] count,
    output logic             hit_two
);
    qsu_state_e state_q;
    qsu_state_e state_d;

    qsu_next u_next (
        .cur      (state_q),
        .dir_down (dir_down),
        .nxt      (state_d)
    );

    qsu_detect u_detect (
        .cur      (state_q),
        .dir_down (dir_down),
        .hit      (hit_two)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ZERO;
        else     state_q <= state_d;
    end

    assign count = state_q;
endmodule

// File: rtl/quad_updown_seek2_chk.sv
module quad_updown_seek2_chk
    import qsu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             dir_down,
    input logic [CNT_W-1:0] count,
    input logic             hit_two
);
    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen)
            p_reset_zero_r1: assert (count == 2'b00)
                else $error("R1 count not zero after reset");
    end

    p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
        !dir_down |=> count == CNT_W'($past(count) + 1'b1));

    p_down_step_r3: assert property (@(posedge clk) disable iff (rst)
        dir_down |=> count == CNT_W'($past(count) - 1'b1));

    p_hit_up_r4: assert property (@(posedge clk) disable iff (rst)
        (count == 2'b01 && !dir_down) |-> hit_two);

    p_hit_down_r5: assert property (@(posedge clk) disable iff (rst)
        (count == 2'b11 && dir_down) |-> hit_two);

    p_hit_lands_r6: assert property (@(posedge clk) disable iff (rst)
        hit_two |=> count == 2'b10);
endmodule

bind quad_updown_seek2 quad_updown_seek2_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dir_down (dir_down),
    .count    (count),
    .hit_two  (hit_two)
);

// File: tb/tb_quad_updown_seek2.sv
`timescale 1ns/1ps
module tb_quad_updown_seek2;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_down = 1'b0;
    logic [1:0] count;
    logic       hit_two;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    quad_updown_seek2 dut (
        .clk(clk), .rst(rst), .dir_down(dir_down),
        .count(count), .hit_two(hit_two)
    );

    // {state, dir, expected next, expected hit}
    localparam logic [5:0] VEC [8] = '{
        {2'b00, 1'b0, 2'b01, 1'b0},
        {2'b01, 1'b0, 2'b10, 1'b1},
        {2'b10, 1'b0, 2'b11, 1'b0},
        {2'b11, 1'b0, 2'b00, 1'b0},
        {2'b00, 1'b1, 2'b11, 1'b0},
        {2'b01, 1'b1, 2'b00, 1'b0},
        {2'b10, 1'b1, 2'b01, 1'b0},
        {2'b11, 1'b1, 2'b10, 1'b1}
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic goto_state(input logic [1:0] s);
        rst = 1'b1; dir_down = 1'b0;
        tick();
        rst = 1'b0;
        for (int k = 0; k < s; k++) tick();
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        check("R1 reset state", count, 2'b00);

        for (int i = 0; i < 8; i++) begin
            logic [1:0] st, nx;
            logic       d, h;
            {st, d, nx, h} = VEC[i];
            goto_state(st);
            dir_down = d;
            #1;
            check(h ? (d ? "R5 hit down" : "R4 hit up") : "R6 no hit", {1'b0, hit_two}, {1'b0, h});
            tick();
            check(d ? "R3 down step" : "R2 up step", count, nx);
        end

        // R7/R8: ONE with up pending, then flip before the edge
        goto_state(2'b01);
        dir_down = 1'b0; #1;
        check("R7 hit before flip", {1'b0, hit_two}, 2'b01);
        dir_down = 1'b1; #0.5;
        check("R7 hit follows dir", {1'b0, hit_two}, 2'b00);
        tick();
        check("R8 edge value decides", count, 2'b00);

        // R7/R8: THREE, flip from up to down mid-cycle
        goto_state(2'b11);
        dir_down = 1'b0; #0.5;
        check("R7 no hit while up", {1'b0, hit_two}, 2'b00);
        dir_down = 1'b1; #0.5;
        check("R7 hit after flip", {1'b0, hit_two}, 2'b01);
        tick();
        check("R8 lands on two", count, 2'b10);

        // R9: reset meets pending arrivals
        goto_state(2'b01);
        dir_down = 1'b0; #0.5;
        check("R9 pending up", {1'b0, hit_two}, 2'b01);
        rst = 1'b1;
        tick();
        check("R9 reset wins up", count, 2'b00);
        rst = 1'b0;
        goto_state(2'b11);
        dir_down = 1'b1; #0.5;
        check("R9 pending down", {1'b0, hit_two}, 2'b01);
        rst = 1'b1;
        tick();
        check("R9 reset wins down", count, 2'b00);
        rst = 1'b0;

        // R2/R3: full wrap in each direction
        dir_down = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check("R2 wrap up", count, 2'(k));
        end
        dir_down = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check("R3 wrap down", count, 2'(0 - k));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule